// File: doc/BRIEF.md
# Two-Port Byte Memory with Shared Semaphore Flags

This block is a synchronous two-port memory of 8192 bytes. Each of the two ports, called left and right, has its own address, data and active-low controls: a chip select, a write strobe, an output enable and a semaphore select. Either port can read or write any word in any cycle, independently of the other. All decoding is sampled on the rising clock edge. Read data, its output-enable, the error flag and the collision flag are registered, so each one appears one cycle after the request.

When a port raises its chip select and pulls its semaphore select low, it reaches a bank of eight shared flags instead of the array. The three lowest address bits select the flag. These flags let software on the two sides share a resource safely. A port claims a flag by writing 0 on data bit 0 and gives it back by writing 1. A claim that cannot be granted at once is remembered and granted later, when the owner lets go. A read of a flag reports 0 on every data bit to the port that owns it, and all ones to anyone else.

A port is deselected when both its chip select and its semaphore select are high. Pulling both low at once is not allowed: the port then raises an error flag and changes nothing.

Top module: `dpram_sem`

## Requirements
- R1: After reset every flag is free, so any flag read returns 8'hFF. Both data output-enables, both error flags and the collision flag are low.
- R2: A port with chip select low, write strobe low and semaphore select high stores its data byte at its address.
- R3: A port with chip select low, write strobe high, output enable low and semaphore select high presents, one cycle later, the addressed word with its output-enable high. The word returned is the content from before any write made on that same edge. In every other non-read case the output-enable is low and the data output is 0.
- R4: A port with semaphore select low, chip select high, write strobe high and output enable low presents, one cycle later, 8'h00 if it owns flag addr[2:0] and 8'hFF otherwise, with its output-enable high.
- R5: A semaphore write (semaphore select low, chip select high, write strobe low) with data bit 0 at 0 claims flag addr[2:0] for the port if no port owns it. The two ports never own the same flag.
- R6: A claim made on a flag that the other port owns stays pending. It is granted on the same edge that the owner releases the flag.
- R7: Writing data bit 0 at 1 releases the flag only if the writing port owns it, and it also withdraws that port's pending claim. A release by a port that does not own the flag leaves the owner unchanged.
- R8: If both ports claim the same free flag in the same cycle, the left port gets it and the right claim stays pending.
- R9: Chip select low together with semaphore select low raises the port's error flag one cycle later. It writes neither the memory nor any flag.
- R10: If both ports write the same memory word in the same cycle, the left port's byte is stored and the collision flag is high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lf_cs_n | input | 1 | Left chip select, active low |
| lf_we_n | input | 1 | Left write strobe, active low |
| lf_oe_n | input | 1 | Left output enable, active low |
| lf_sem_n | input | 1 | Left semaphore select, active low |
| lf_addr | input | 13 | Left address |
| lf_din | input | 8 | Left write data |
| lf_dout | output | 8 | Left read data |
| lf_doe | output | 1 | Left read data valid / drive enable |
| lf_err | output | 1 | Left illegal-control flag |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_we_n | input | 1 | Right write strobe, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_sem_n | input | 1 | Right semaphore select, active low |
| rt_addr | input | 13 | Right address |
| rt_din | input | 8 | Right write data |
| rt_dout | output | 8 | Right read data |
| rt_doe | output | 1 | Right read data valid / drive enable |
| rt_err | output | 1 | Right illegal-control flag |
| wr_collide | output | 1 | Both ports wrote the same word |

## Verification
The flag ownership and the pending claims are hidden state. A wrong owner shows up only when a later flag read from either port returns the wrong code. A lost pending claim shows up only after the owner's release, as an FF that should have been 00. For that reason the bench repeats flag reads from both ports after each claim and each release, so that a bad ownership record appears one cycle after the read. A corrupted memory word shows up at the next read of that address. Illegal accesses and collisions are followed at once by reads that expose any change they should not have made.

// File: rtl/dpram_sem.sv
module dpram_sem #(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int NSEM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_cs_n,
  input  logic          lf_we_n,
  input  logic          lf_oe_n,
  input  logic          lf_sem_n,
  input  logic [AW-1:0] lf_addr,
  input  logic [DW-1:0] lf_din,
  output logic [DW-1:0] lf_dout,
  output logic          lf_doe,
  output logic          lf_err,
  input  logic          rt_cs_n,
  input  logic          rt_we_n,
  input  logic          rt_oe_n,
  input  logic          rt_sem_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_din,
  output logic [DW-1:0] rt_dout,
  output logic          rt_doe,
  output logic          rt_err,
  output logic          wr_collide
);
  localparam int DEPTH = 1 << AW;
  localparam int SW    = $clog2(NSEM);

  logic [DW-1:0] mem [DEPTH];

  wire l_mw = !lf_cs_n && !lf_we_n && lf_sem_n;
  wire l_mr = !lf_cs_n && lf_we_n && !lf_oe_n && lf_sem_n;
  wire l_sr = lf_cs_n && !lf_sem_n && lf_we_n && !lf_oe_n;
  wire l_sw = lf_cs_n && !lf_sem_n && !lf_we_n;
  wire r_mw = !rt_cs_n && !rt_we_n && rt_sem_n;
  wire r_mr = !rt_cs_n && rt_we_n && !rt_oe_n && rt_sem_n;
  wire r_sr = rt_cs_n && !rt_sem_n && rt_we_n && !rt_oe_n;
  wire r_sw = rt_cs_n && !rt_sem_n && !rt_we_n;
  wire [SW-1:0] l_sel = lf_addr[SW-1:0];
  wire [SW-1:0] r_sel = rt_addr[SW-1:0];

  logic [NSEM-1:0] own_l, own_r, pend_l, pend_r;
  logic [NSEM-1:0] own_l_d, own_r_d, pend_l_d, pend_r_d;

  always_comb begin
    for (int i = 0; i < NSEM; i++) begin
      logic hit_l, hit_r, keep_l, keep_r, want_l, want_r;
      hit_l  = l_sw && (l_sel == SW'(i));
      hit_r  = r_sw && (r_sel == SW'(i));
      keep_l = own_l[i] && !(hit_l && lf_din[0]);
      keep_r = own_r[i] && !(hit_r && rt_din[0]);
      want_l = hit_l ? !lf_din[0] : pend_l[i];
      want_r = hit_r ? !rt_din[0] : pend_r[i];
      own_l_d[i] = keep_l || (!keep_r && want_l);
      own_r_d[i] = keep_r || (!keep_l && !want_l && want_r);
      pend_l_d[i] = want_l && !own_l_d[i];
      pend_r_d[i] = want_r && !own_r_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l <= '0; own_r <= '0; pend_l <= '0; pend_r <= '0;
    end else begin
      own_l <= own_l_d; own_r <= own_r_d;
      pend_l <= pend_l_d; pend_r <= pend_r_d;
    end
  end

  always_ff @(posedge clk) begin
    if (r_mw) mem[rt_addr] <= rt_din;
    if (l_mw) mem[lf_addr] <= lf_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_doe <= 1'b0; lf_dout <= '0; lf_err <= 1'b0;
      rt_doe <= 1'b0; rt_dout <= '0; rt_err <= 1'b0;
      wr_collide <= 1'b0;
    end else begin
      lf_doe  <= l_mr || l_sr;
      lf_dout <= l_mr ? mem[lf_addr] : (l_sr ? {DW{!own_l[l_sel]}} : '0);
      lf_err  <= !lf_cs_n && !lf_sem_n;
      rt_doe  <= r_mr || r_sr;
      rt_dout <= r_mr ? mem[rt_addr] : (r_sr ? {DW{!own_r[r_sel]}} : '0);
      rt_err  <= !rt_cs_n && !rt_sem_n;
      wr_collide <= l_mw && r_mw && (lf_addr == rt_addr);
    end
  end
endmodule

// File: rtl/dpram_sem_chk.sv
module dpram_sem_chk #(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int NSEM = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lf_cs_n, lf_we_n, lf_oe_n, lf_sem_n,
  input logic [AW-1:0]   lf_addr,
  input logic [DW-1:0]   lf_din,
  input logic [DW-1:0]   lf_dout,
  input logic            lf_doe, lf_err,
  input logic            rt_cs_n, rt_we_n, rt_oe_n, rt_sem_n,
  input logic [AW-1:0]   rt_addr,
  input logic [DW-1:0]   rt_din,
  input logic            wr_collide,
  input logic [NSEM-1:0] own_l, own_r, pend_r
);
  localparam int SW = $clog2(NSEM);
  wire [SW-1:0] ls = lf_addr[SW-1:0];
  wire [SW-1:0] rs = rt_addr[SW-1:0];
  wire lsw = lf_cs_n && !lf_sem_n && !lf_we_n;
  wire rsw = rt_cs_n && !rt_sem_n && !rt_we_n;
  wire lsr = lf_cs_n && !lf_sem_n && lf_we_n && !lf_oe_n;
  wire lmw = !lf_cs_n && !lf_we_n && lf_sem_n;
  wire rmw = !rt_cs_n && !rt_we_n && rt_sem_n;

  assert_free_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (own_l == '0 && own_r == '0));
  assert_flag_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsr |=> lf_doe && (lf_dout == '0 || lf_dout == '1));
  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);
  assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsw && lf_din[0] && own_l[ls] && pend_r[ls] && !rsw) |=> own_r[$past(ls)]);
  assert_left_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsw && rsw && ls == rs && !lf_din[0] && !rt_din[0] && !own_l[ls] && !own_r[ls])
      |=> own_l[$past(ls)]);
  assert_illegal_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lf_cs_n && !lf_sem_n && rt_cs_n && rt_sem_n) |=> lf_err && $stable(own_l) && $stable(own_r));
  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lmw && rmw && lf_addr == rt_addr) |=> wr_collide);
endmodule

bind dpram_sem dpram_sem_chk #(.AW(AW), .DW(DW), .NSEM(NSEM)) u_chk (.*);

// File: tb/tb_dpram_sem.sv
module tb_dpram_sem;
  localparam int PERIOD = 10;
  localparam int OP_IDLE = 0, OP_MW = 1, OP_MR = 2, OP_SR = 3, OP_SW = 4, OP_ILL = 5, OP_OFF = 6;

  logic clk = 0, rst_n = 0;
  logic lcs = 1, lwe = 1, loe = 1, lsem = 1, rcs = 1, rwe = 1, roe = 1, rsem = 1;
  logic [12:0] la = 0, ra = 0;
  logic [7:0] ld = 0, rd = 0;
  logic [7:0] ldo, rdo;
  logic ldoe, rdoe, lerr, rerr, coll;

  dpram_sem dut (
    .clk(clk), .rst_n(rst_n),
    .lf_cs_n(lcs), .lf_we_n(lwe), .lf_oe_n(loe), .lf_sem_n(lsem),
    .lf_addr(la), .lf_din(ld), .lf_dout(ldo), .lf_doe(ldoe), .lf_err(lerr),
    .rt_cs_n(rcs), .rt_we_n(rwe), .rt_oe_n(roe), .rt_sem_n(rsem),
    .rt_addr(ra), .rt_din(rd), .rt_dout(rdo), .rt_doe(rdoe), .rt_err(rerr),
    .wr_collide(coll));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string ctx = "R1";
  logic [7:0] mm [8192];
  bit vld [8192];
  int owner [8];
  bit pl [8], pr [8];
  logic [7:0] e_ldo, e_rdo;
  bit e_ldoe, e_rdoe, e_lerr, e_rerr, e_coll, e_lv, e_rv;
  string t_l, t_r;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, ctx, $time, act, exp);
    end
  endtask

  task automatic setp(bit left, int op, int a, int d);
    logic cs, we, oe, sm;
    case (op)
      OP_MW:   begin cs = 0; we = 0; oe = 1; sm = 1; end
      OP_MR:   begin cs = 0; we = 1; oe = 0; sm = 1; end
      OP_SR:   begin cs = 1; we = 1; oe = 0; sm = 0; end
      OP_SW:   begin cs = 1; we = 0; oe = 1; sm = 0; end
      OP_ILL:  begin cs = 0; we = 0; oe = 1; sm = 0; end
      OP_OFF:  begin cs = 0; we = 1; oe = 1; sm = 1; end
      default: begin cs = 1; we = 1; oe = 1; sm = 1; end
    endcase
    if (left) begin lcs = cs; lwe = we; loe = oe; lsem = sm; la = 13'(a); ld = 8'(d); end
    else      begin rcs = cs; rwe = we; roe = oe; rsem = sm; ra = 13'(a); rd = 8'(d); end
  endtask

  task automatic model();
    bit lmw, lmr, lsr, lsw, rmw, rmr, rsr, rsw;
    lmw = !lcs && !lwe && lsem;  lmr = !lcs && lwe && !loe && lsem;
    lsr = lcs && !lsem && lwe && !loe;  lsw = lcs && !lsem && !lwe;
    rmw = !rcs && !rwe && rsem;  rmr = !rcs && rwe && !roe && rsem;
    rsr = rcs && !rsem && rwe && !roe;  rsw = rcs && !rsem && !rwe;
    e_ldoe = lmr || lsr; e_rdoe = rmr || rsr;
    e_lv = 1; e_rv = 1; t_l = lsr ? "R4" : "R3"; t_r = rsr ? "R4" : "R3";
    e_ldo = 0; e_rdo = 0;
    if (lmr) begin e_ldo = mm[la]; e_lv = vld[la]; end
    if (lsr) e_ldo = (owner[la[2:0]] == 1) ? 8'h00 : 8'hFF;
    if (rmr) begin e_rdo = mm[ra]; e_rv = vld[ra]; end
    if (rsr) e_rdo = (owner[ra[2:0]] == 2) ? 8'h00 : 8'hFF;
    e_lerr = !lcs && !lsem; e_rerr = !rcs && !rsem;
    e_coll = lmw && rmw && la == ra;
    if (rmw) begin mm[ra] = rd; vld[ra] = 1; end
    if (lmw) begin mm[la] = ld; vld[la] = 1; end
    for (int f = 0; f < 8; f++) begin
      int o = owner[f];
      if (lsw && la[2:0] == f) begin
        if (ld[0]) begin if (o == 1) o = 0; pl[f] = 0; end else pl[f] = 1;
      end
      if (rsw && ra[2:0] == f) begin
        if (rd[0]) begin if (o == 2) o = 0; pr[f] = 0; end else pr[f] = 1;
      end
      if (o == 0) begin if (pl[f]) o = 1; else if (pr[f]) o = 2; end
      if (o == 1) pl[f] = 0;
      if (o == 2) pr[f] = 0;
      owner[f] = o;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(ldoe == e_ldoe, t_l, ldoe, e_ldoe);
    if (e_lv) chk(ldo == e_ldo, t_l, ldo, e_ldo);
    chk(rdoe == e_rdoe, t_r, rdoe, e_rdoe);
    if (e_rv) chk(rdo == e_rdo, t_r, rdo, e_rdo);
    chk(lerr == e_lerr, "R9", lerr, e_lerr);
    chk(rerr == e_rerr, "R9", rerr, e_rerr);
    chk(coll == e_coll, "R10", coll, e_coll);
  endtask

  task automatic go(int lop, int lad, int ldt, int rop, int rad, int rdt);
    setp(1, lop, lad, ldt); setp(0, rop, rad, rdt); step();
  endtask

  task automatic readflags(int f);
    go(OP_SR, f, 0, OP_SR, f, 0);
  endtask

  initial begin
    for (int f = 0; f < 8; f++) begin owner[f] = 0; pl[f] = 0; pr[f] = 0; end
    repeat (3) @(negedge clk);
    chk(ldoe == 0 && rdoe == 0 && lerr == 0 && rerr == 0 && coll == 0, "R1", ldoe, 0);
    rst_n = 1;
    ctx = "R1";
    for (int f = 0; f < 8; f++) readflags(f);
    go(OP_IDLE, 0, 0, OP_IDLE, 0, 0);
    ctx = "R2";
    go(OP_MW, 0, 8'hA5, OP_MW, 8191, 8'h3C);
    go(OP_MW, 5, 8'h11, OP_MW, 3, 8'h22);
    ctx = "R3";
    go(OP_MR, 8191, 0, OP_MR, 0, 0);
    go(OP_OFF, 0, 0, OP_MR, 5, 0);
    go(OP_MW, 5, 8'h77, OP_MR, 5, 0);
    go(OP_MR, 5, 0, OP_IDLE, 0, 0);
    ctx = "R5";
    go(OP_SW, 2, 0, OP_IDLE, 0, 0);
    readflags(2);
    ctx = "R6";
    go(OP_IDLE, 0, 0, OP_SW, 2, 0);
    readflags(2);
    go(OP_SW, 2, 1, OP_IDLE, 0, 0);
    readflags(2);
    ctx = "R7";
    go(OP_SW, 2, 1, OP_IDLE, 0, 0);
    readflags(2);
    go(OP_SW, 2, 0, OP_IDLE, 0, 0);
    go(OP_SW, 2, 1, OP_IDLE, 0, 0);
    go(OP_IDLE, 0, 0, OP_SW, 2, 1);
    readflags(2);
    ctx = "R8";
    go(OP_SW, 5, 0, OP_SW, 5, 0);
    readflags(5);
    ctx = "R9";
    go(OP_ILL, 5, 1, OP_IDLE, 0, 0);
    readflags(5);
    go(OP_ILL, 3, 8'hEE, OP_ILL, 0, 8'h99);
    go(OP_MR, 3, 0, OP_MR, 0, 0);
    ctx = "R6";
    go(OP_SW, 5, 1, OP_IDLE, 0, 0);
    readflags(5);
    ctx = "R10";
    go(OP_MW, 3, 8'h5A, OP_MW, 3, 8'hC3);
    go(OP_MR, 3, 0, OP_MR, 3, 0);
    ctx = "R2";
    for (int i = 0; i < 3000; i++) begin
      int lo = $urandom_range(0, 6), ro = $urandom_range(0, 6);
      int lad = $urandom_range(0, 7), rad = $urandom_range(0, 7);
      if (lad == 7) lad = 8191;
      if (rad == 7) rad = 8191;
      go(lo, lad, $urandom_range(0, 255), ro, rad, $urandom_range(0, 255));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog (%s) actual=hung expected=done", ctx);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule